// File: doc/BRIEF.md
# Flash command sequence decoder

This block models the write-side command interface of a parallel NOR flash in synthesizable form. An external master drives an asynchronous write bus made of an active-low chip enable, an active-low write enable, an address and a byte of data. The block samples these pins into its own clock and treats each low pulse of the combined strobe as one bus write. The address is taken at the start of the pulse and the data at its end. A small decoder follows the multi-write unlock sequences and turns them into three kinds of request: program one word, erase the whole array, or erase one sector.

Programming and chip erase act on a small internal array. A program can only clear bits: the new word is the old word ANDed with the written byte. Chip erase runs an embedded operation that first writes zero to every word and then sets every word to all ones. Each word costs a fixed number of clock cycles, set by a parameter. While an embedded operation runs, reads return a status byte instead of array data, and bit 7 of that byte tells the master when the operation has finished. Sector erase is not executed here. The block issues a one-cycle request with the sector index, and a separate block that owns the erase timing window picks it up.

The read side is a plain registered port that follows the bus address. There is no stream traffic at the edges of this block, so it has no valid/ready handshake. The master is responsible for pacing: it must hold the address and data stable for at least three clock cycles after the strobe edge that captures them.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every array word reads 8'hFF and `sec_erase_req` is low.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h followed by a data write program one word, selected by the low log2(WORDS) address bits. The word becomes old AND data, and programs may target any word in any order, across sector boundaries.
- R3: Writing a 1 over a stored 0 leaves the 0: a program with FFh or with a value that has new 1 bits never sets a cleared bit.
- R4: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h start a chip erase. It zeroes every word in index order, then sets every word to FFh in index order, and afterwards every word reads FFh.
- R5: A read taken while an embedded operation runs returns bits 6:0 as zero and bit 7 as the complement of bit 7 of the final value. For chip erase the final value is FFh, so the read returns 00h. Once the operation is done, reads return array data.
- R6: The same five-write prefix followed by 30h at any address pulses `sec_erase_req` for exactly one cycle. `sec_erase_sel` carries the word index divided by SECTOR_WORDS, and the array is unchanged.
- R7: A write that does not match the expected next step of a sequence returns the decoder to idle with no array change. That write is not taken as the first step of a new sequence.
- R8: A write of F0h at any step, including the program data step, returns the decoder to idle with no effect.
- R9: Writes that complete while an embedded operation is busy are discarded by the decoder. They cause no request, and the decoder is idle when the operation ends.
- R10: A bus write is a low pulse on `bus_we_n` while `bus_ce_n` is low. The address is captured at the start of the pulse and the data at its end. A `bus_we_n` pulse with `bus_ce_n` high is no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Active-low chip enable of the write bus |
| bus_we_n | input | 1 | Active-low write enable of the write bus |
| bus_addr | input | ADDR_W | Bus address, used for writes and for reads |
| bus_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data, array word or status byte |
| sec_erase_req | output | 1 | One-cycle sector erase request |
| sec_erase_sel | output | SEC_W | Sector index of the request |

## Verification
Two of the block's functions can land in the same cycle: a sampled bus write reaching the sequence decoder, and the embedded engine being busy. The bench provokes this by issuing a full program sequence and a full sector-erase sequence while a chip erase is running. It judges the result in three ways: no sector pulse may appear, the targeted word must read FFh once the erase is done, and a clean program issued afterwards must take effect. That last check shows the decoder came back to idle rather than stopping partway through a sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DATA_W = 8;
  localparam int MATCH_W = 11;

  localparam logic [DATA_W-1:0] CMD_KEY1  = 8'hAA;
  localparam logic [DATA_W-1:0] CMD_KEY2  = 8'h55;
  localparam logic [DATA_W-1:0] CMD_PROG  = 8'hA0;
  localparam logic [DATA_W-1:0] CMD_SETUP = 8'h80;
  localparam logic [DATA_W-1:0] CMD_CHIP  = 8'h10;
  localparam logic [DATA_W-1:0] CMD_SECT  = 8'h30;
  localparam logic [DATA_W-1:0] CMD_ABORT = 8'hF0;

  localparam logic [MATCH_W-1:0] LOC_KEY1 = 11'h555;
  localparam logic [MATCH_W-1:0] LOC_KEY2 = 11'h2AA;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PDATA, SQ_SETUP, SQ_EK1, SQ_EK2
  } seq_state_t;

  typedef enum logic [1:0] {
    EN_IDLE, EN_PROG, EN_ZERO, EN_ONES
  } eng_state_t;
endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
  parameter int ADDR_W = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int HIST_W = SYNC_STAGES + 1;

  logic [HIST_W-1:0] strb_q;
  logic              strb_raw, strb_now, strb_prev, strb_start, strb_end;
  logic [ADDR_W-1:0] addr_lat;

  assign strb_raw   = ~bus_ce_n & ~bus_we_n;
  assign strb_now   = strb_q[SYNC_STAGES-1];
  assign strb_prev  = strb_q[SYNC_STAGES];
  assign strb_start = strb_now & ~strb_prev;
  assign strb_end   = ~strb_now & strb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q   <= '0;
      addr_lat <= '0;
      wr_evt   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      strb_q <= {strb_q[HIST_W-2:0], strb_raw};
      wr_evt <= strb_end;
      if (strb_start) addr_lat <= bus_addr;
      if (strb_end) begin
        wr_addr <= addr_lat;
        wr_data <= bus_data;
      end
    end
  end
endmodule

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int IDX_W = 4,
  parameter int SEC_SH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_evt,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                eng_busy,
  output logic                prog_req,
  output logic [IDX_W-1:0]    prog_idx,
  output logic [7:0]          prog_data,
  output logic                chip_req,
  output logic                sec_req,
  output logic [IDX_W-SEC_SH-1:0] sec_sel
);
  seq_state_t       st;
  logic             evt_ok, at_key1, at_key2, is_key1, is_key2;
  logic [IDX_W-1:0] idx;

  assign evt_ok  = wr_evt & ~eng_busy;
  assign at_key1 = (wr_addr[MATCH_W-1:0] == LOC_KEY1);
  assign at_key2 = (wr_addr[MATCH_W-1:0] == LOC_KEY2);
  assign is_key1 = at_key1 && (wr_data == CMD_KEY1);
  assign is_key2 = at_key2 && (wr_data == CMD_KEY2);
  assign idx     = wr_addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      prog_req  <= 1'b0;
      prog_idx  <= '0;
      prog_data <= '0;
      chip_req  <= 1'b0;
      sec_req   <= 1'b0;
      sec_sel   <= '0;
    end else begin
      prog_req <= 1'b0;
      chip_req <= 1'b0;
      sec_req  <= 1'b0;
      if (evt_ok) begin
        if (wr_data == CMD_ABORT) begin
          st <= SQ_IDLE;
        end else begin
          unique case (st)
            SQ_IDLE:  st <= is_key1 ? SQ_K1 : SQ_IDLE;
            SQ_K1:    st <= is_key2 ? SQ_K2 : SQ_IDLE;
            SQ_K2: begin
              if (at_key1 && wr_data == CMD_PROG)       st <= SQ_PDATA;
              else if (at_key1 && wr_data == CMD_SETUP) st <= SQ_SETUP;
              else                                      st <= SQ_IDLE;
            end
            SQ_PDATA: begin
              prog_req  <= 1'b1;
              prog_idx  <= idx;
              prog_data <= wr_data;
              st        <= SQ_IDLE;
            end
            SQ_SETUP: st <= is_key1 ? SQ_EK1 : SQ_IDLE;
            SQ_EK1:   st <= is_key2 ? SQ_EK2 : SQ_IDLE;
            SQ_EK2: begin
              if (at_key1 && wr_data == CMD_CHIP) begin
                chip_req <= 1'b1;
              end else if (wr_data == CMD_SECT) begin
                sec_req <= 1'b1;
                sec_sel <= idx[IDX_W-1:SEC_SH];
              end
              st <= SQ_IDLE;
            end
            default:  st <= SQ_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_embedded_engine.sv
module flash_embedded_engine
  import flash_cmd_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int IDX_W = 4,
  parameter int WORD_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_req,
  input  logic [IDX_W-1:0] prog_idx,
  input  logic [7:0]       prog_data,
  input  logic             chip_req,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  output logic [7:0]       rd_data
);
  localparam int CNT_W = (WORD_CYCLES > 1) ? $clog2(WORD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_CYCLES - 1);
  localparam logic [IDX_W-1:0] LAST_W   = IDX_W'(WORDS - 1);

  eng_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] widx, tgt_idx;
  logic [7:0]       tgt_val;
  logic [7:0]       mem [WORDS];
  logic             stat7;

  assign busy  = (st != EN_IDLE);
  assign stat7 = (st == EN_PROG) ? tgt_val[7] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= EN_IDLE;
      cnt     <= '0;
      widx    <= '0;
      tgt_idx <= '0;
      tgt_val <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= 8'hFF;
    end else if (st == EN_IDLE) begin
      cnt  <= '0;
      widx <= '0;
      if (prog_req) begin
        tgt_idx <= prog_idx;
        tgt_val <= mem[prog_idx] & prog_data;
        st      <= EN_PROG;
      end else if (chip_req) begin
        st <= EN_ZERO;
      end
    end else if (cnt != LAST_CNT) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      unique case (st)
        EN_PROG: begin
          mem[tgt_idx] <= tgt_val;
          st           <= EN_IDLE;
        end
        EN_ZERO: begin
          mem[widx] <= 8'h00;
          if (widx == LAST_W) begin
            widx <= '0;
            st   <= EN_ONES;
          end else begin
            widx <= widx + 1'b1;
          end
        end
        EN_ONES: begin
          mem[widx] <= 8'hFF;
          if (widx == LAST_W) st <= EN_IDLE;
          else                widx <= widx + 1'b1;
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_data <= 8'h00;
    else if (busy) rd_data <= {~stat7, 7'b0};
    else           rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W = 11,
  parameter int WORDS = 16,
  parameter int SECTOR_WORDS = 4,
  parameter int WORD_CYCLES = 8,
  localparam int IDX_W = $clog2(WORDS),
  localparam int SEC_SH = $clog2(SECTOR_WORDS),
  localparam int SEC_W = IDX_W - SEC_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  output logic [7:0]        rd_data,
  output logic              sec_erase_req,
  output logic [SEC_W-1:0]  sec_erase_sel
);
  logic              wr_evt;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              eng_busy, prog_req, chip_req;
  logic [IDX_W-1:0]  prog_idx;
  logic [7:0]        prog_data;

  flash_bus_sampler #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_sampler (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_seq_decoder #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEC_SH(SEC_SH)) u_decoder (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_busy(eng_busy),
    .prog_req(prog_req), .prog_idx(prog_idx), .prog_data(prog_data),
    .chip_req(chip_req), .sec_req(sec_erase_req), .sec_sel(sec_erase_sel)
  );

  flash_embedded_engine #(.WORDS(WORDS), .IDX_W(IDX_W), .WORD_CYCLES(WORD_CYCLES)) u_engine (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_idx(prog_idx),
    .prog_data(prog_data), .chip_req(chip_req),
    .rd_idx(bus_addr[IDX_W-1:0]), .busy(eng_busy), .rd_data(rd_data)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_evt,
  input logic       busy,
  input logic       prog_req,
  input logic       chip_req,
  input logic       sec_req,
  input logic [7:0] rd_data
);
  assert_status_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (rd_data[6:0] == 7'd0));

  assert_sec_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_req |=> !sec_req);

  assert_sec_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_req |-> !busy);

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_evt) |=> !(prog_req || chip_req || sec_req));

  assert_req_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || chip_req) |-> !busy);

  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_req || chip_req));

  assert_evt_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .busy(eng_busy),
  .prog_req(prog_req), .chip_req(chip_req), .sec_req(sec_erase_req),
  .rd_data(rd_data)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  localparam int AW = 11;
  localparam int WC = 40;
  localparam int PROG_WAIT = WC + 30;
  localparam int ERASE_WAIT = 2 * 16 * WC + 120;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_ce_n = 1'b1;
  logic          bus_we_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_data = '0;
  logic [7:0]    rd_data;
  logic          sec_erase_req;
  logic [1:0]    sec_erase_sel;

  always #4 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .WORDS(16), .SECTOR_WORDS(4), .WORD_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .rd_data(rd_data),
    .sec_erase_req(sec_erase_req), .sec_erase_sel(sec_erase_sel)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [7:0]    exp;
    string         tag;
  } rd_item_t;

  rd_item_t   rq[$];
  logic [1:0] sq[$];
  rd_item_t   cur;
  logic [1:0] sexp;
  int         n_cmp = 0;
  int         n_bad = 0;
  logic       mon_fire = 1'b0;
  logic       done = 1'b0;

  // monitor: pops expected items as the design produces results
  always @(negedge clk) begin
    if (mon_fire) begin
      n_cmp++;
      if (rq.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: read with no expected item, got %h exp none", rd_data);
      end else begin
        cur = rq.pop_front();
        if (rd_data !== cur.exp) begin
          n_bad++;
          $display("FAIL %s: addr %h got %h exp %h", cur.tag, cur.a, rd_data, cur.exp);
        end
      end
    end
    if (rst_n && sec_erase_req) begin
      n_cmp++;
      if (sq.size() == 0) begin
        n_bad++;
        $display("FAIL R6/R9: unexpected sector request, got sel %0d exp no pulse", sec_erase_sel);
      end else begin
        sexp = sq.pop_front();
        if (sec_erase_sel !== sexp) begin
          n_bad++;
          $display("FAIL R6: sector sel got %0d exp %0d", sec_erase_sel, sexp);
        end
      end
    end
  end

  task automatic expect_rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    it.a = a; it.exp = e; it.tag = tag;
    rq.push_back(it);
    @(negedge clk); bus_addr = a;
    @(posedge clk); @(posedge clk); #1 mon_fire = 1'b1;
    @(posedge clk); #1 mon_fire = 1'b0;
  endtask

  // address at pulse start is a, replaced by a_late before the end; data is
  // only valid shortly before the end of the pulse (R10)
  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [AW-1:0] a_late, input logic ce_on);
    @(negedge clk); bus_addr = a; bus_data = ~d; bus_ce_n = ~ce_on;
    @(negedge clk); bus_we_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_addr = a_late; bus_data = d;
    @(negedge clk); bus_we_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_wr(a, d, a, 1'b1);
  endtask

  task automatic keys();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    keys();
    wr(11'h555, 8'hA0);
    wr(a, d);
  endtask

  task automatic erase_prefix();
    keys();
    wr(11'h555, 8'h80);
    keys();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    n_cmp++;
    if (sec_erase_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: sec_erase_req got %b exp 0", sec_erase_req);
    end
    expect_rd(11'h000, 8'hFF, "R1");
    expect_rd(11'h005, 8'hFF, "R1");
    expect_rd(11'h00F, 8'hFF, "R1");

    // R2 + R5: program, status while busy (bit7 = ~0 -> 80h)
    prog(11'h003, 8'h5A);
    expect_rd(11'h003, 8'h80, "R5 program status");
    idle(PROG_WAIT);
    expect_rd(11'h003, 8'h5A, "R2");

    // R3: program can only clear bits
    prog(11'h003, 8'h3C);
    idle(PROG_WAIT);
    expect_rd(11'h003, 8'h18, "R3 and");
    prog(11'h003, 8'hFF);
    idle(PROG_WAIT);
    expect_rd(11'h003, 8'h18, "R3 ones ignored");

    // R2: any order, other sectors, index from low address bits
    prog(11'h00E, 8'h81);
    expect_rd(11'h00E, 8'h00, "R5 program status bit7 set");
    idle(PROG_WAIT);
    expect_rd(11'h00E, 8'h81, "R2 sector 3");
    prog(11'h101, 8'h7E);
    idle(PROG_WAIT);
    expect_rd(11'h001, 8'h7E, "R2 low index bits");

    // R7: broken sequences
    keys();
    wr(11'h555, 8'h33);
    wr(11'h003, 8'h00);
    idle(PROG_WAIT);
    expect_rd(11'h003, 8'h18, "R7 bad command");
    wr(11'h555, 8'hAA);
    wr(11'h123, 8'h55);
    wr(11'h555, 8'hA0);
    wr(11'h003, 8'h00);
    idle(PROG_WAIT);
    expect_rd(11'h003, 8'h18, "R7 bad address");

    // R8: abort at program data step and inside erase prefix
    keys();
    wr(11'h555, 8'hA0);
    wr(11'h003, 8'hF0);
    wr(11'h00E, 8'h00);
    idle(PROG_WAIT);
    expect_rd(11'h00E, 8'h81, "R8 abort data step");
    expect_rd(11'h003, 8'h18, "R8 abort data step");
    keys();
    wr(11'h555, 8'h80);
    wr(11'h555, 8'hAA);
    wr(11'h555, 8'hF0);
    wr(11'h2AA, 8'h55);
    wr(11'h555, 8'h10);
    expect_rd(11'h00E, 8'h81, "R8 abort erase prefix");

    // R10: strobe needs chip enable; address at start, data at end
    bus_wr(11'h555, 8'hAA, 11'h555, 1'b0);
    bus_wr(11'h2AA, 8'h55, 11'h2AA, 1'b0);
    bus_wr(11'h555, 8'hA0, 11'h555, 1'b0);
    bus_wr(11'h000, 8'h00, 11'h000, 1'b0);
    idle(PROG_WAIT);
    expect_rd(11'h000, 8'hFF, "R10 ce high");
    keys();
    wr(11'h555, 8'hA0);
    bus_wr(11'h002, 8'h11, 11'h009, 1'b1);
    idle(PROG_WAIT);
    expect_rd(11'h002, 8'h11, "R10 address at start");
    expect_rd(11'h009, 8'hFF, "R10 late address unused");

    // R6: sector erase request, array untouched
    sq.push_back(2'd3);
    erase_prefix();
    wr(11'h00D, 8'h30);
    idle(10);
    expect_rd(11'h00E, 8'h81, "R6 array unchanged");

    // R4, R5, R9: chip erase with writes issued while busy
    erase_prefix();
    wr(11'h555, 8'h10);
    expect_rd(11'h003, 8'h00, "R5 erase status");
    prog(11'h005, 8'h00);
    erase_prefix();
    wr(11'h004, 8'h30);
    expect_rd(11'h005, 8'h00, "R5 R9 still busy");
    idle(ERASE_WAIT);
    for (int i = 0; i < 16; i++) expect_rd(AW'(i), 8'hFF, "R4 all ones");
    prog(11'h005, 8'h0F);
    idle(PROG_WAIT);
    expect_rd(11'h005, 8'h0F, "R9 decoder idle after busy");

    idle(10);
    n_cmp++;
    if (sq.size() != 0) begin
      n_bad++;
      $display("FAIL R6: missing sector requests got %0d pending exp 0", sq.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule